// File: doc/BRIEF.md
# Priority Interrupt Controller

This block collects a set of level-sensitive interrupt request lines and decides which one, if any, the processor core should take next. Every source carries a 2-bit priority select field held in a small register bank. The field both enables the source and chooses its level. A separate arbiter for each of the four levels finds the winner within that level. A final stage takes the highest level that the core's 2-bit interrupt mask lets through. Below every level sits one lowest-priority software interrupt request.

When a request is accepted, the block raises a request strobe towards the core. With it, it presents a vector address, which is a programmable base plus twice the winning source index, and the new priority level. The strobe and its vector and level stay frozen until the core pulses an acknowledge. A wake output tells clock control that an accepted request is pending, so the core can leave wait or stop modes. Software reaches the base and the priority fields through a plain write/read port with a combinational read.

The first `N_DBG` source indices form the debug class. The remaining indices form the peripheral class.

Top module: `prio_intc`

## Requirements
- R1: After reset, `int_req` and `wake` are 0, the vector base reads 0 and every priority field reads 00, so that no source is enabled.
- R2: A source whose priority field is 00 is disabled: its request line never causes acceptance and never affects arbitration.
- R3: Debug-class sources (index < `N_DBG`) decode field codes 01/10/11 to levels 1/2/3. Peripheral-class sources decode 01/10/11 to levels 0/1/2.
- R4: Among the enabled, requesting and unmasked sources, the one at the highest level wins. Within one level, the lowest source index wins.
- R5: A request at level L is accepted only when L is greater than or equal to `core_mask`. A level-3 request is therefore always accepted.
- R6: The lowest-priority software request `swi_lp` loses to any accepted source. It is accepted only when `core_mask` is 0, and it reports level 0 with vector base + 2·`N_SRC`.
- R7: On acceptance, `int_vec` equals the base + 2·(winning index) and `int_lvl` equals the winning level. Both appear one clock after the request is presented.
- R8: Once `int_req` is asserted, it stays asserted with `int_vec` and `int_lvl` unchanged until `int_ack` is sampled high, whatever the requests and the mask do in the meantime.
- R9: `int_ack` while `int_req` is high clears `int_req` at that edge. Arbitration resumes on the next edge.
- R10: `wake` is high whenever `int_req` is high, and also whenever a request is currently acceptable.
- R11: A write with `reg_we` at address 0 sets the vector base. A write at address 1+k sets the 2-bit field of source k. `reg_rdata` returns the addressed register, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register address (0 = base, 1+k = field of source k) |
| reg_wdata | input | VEC_W | Register write data |
| reg_rdata | output | VEC_W | Register read data |
| irq_req | input | N_SRC | Source request lines, level-sensitive |
| swi_lp | input | 1 | Lowest-priority software interrupt request |
| core_mask | input | 2 | Core interrupt mask value |
| int_ack | input | 1 | Core acknowledge pulse |
| int_req | output | 1 | Interrupt request strobe to the core |
| int_vec | output | VEC_W | Vector table address |
| int_lvl | output | 2 | New priority level |
| wake | output | 1 | Clock restart request |

## Verification
The hardest situation to reach is one where the held vector and the live arbitration disagree. This happens when a higher-priority request arrives after `int_req` is already up, and the outputs must stay frozen until the acknowledge. After that, the newer winner must appear. The bench builds this on purpose: it accepts a low peripheral source, then raises a level-3 debug source, holds it for several cycles, and acknowledges while that source is still requesting. The wider sweep covers every request pattern with and without the software request, under all four mask values and several field layouts. These layouts are computed so that both classes, disabled fields and ties within a level all occur.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N_SRC  = 8,
  parameter int N_DBG  = 2,
  parameter int VEC_W  = 16,
  parameter int ADDR_W = $clog2(N_SRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [VEC_W-1:0]  reg_wdata,
  output logic [VEC_W-1:0]  reg_rdata,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic              swi_lp,
  input  logic [1:0]        core_mask,
  input  logic              int_ack,
  output logic              int_req,
  output logic [VEC_W-1:0]  int_vec,
  output logic [1:0]        int_lvl,
  output logic              wake
);
  localparam int IDX_W = $clog2(N_SRC + 1);

  logic [VEC_W-1:0] base_q;
  logic [1:0]       fld_q [N_SRC];
  logic [1:0]       lvl_of [N_SRC];
  logic [N_SRC-1:0] hit [4];
  logic [3:0]       lvl_found;
  logic [IDX_W-1:0] lvl_idx [4];

  logic             acc;
  logic [1:0]       win_lvl;
  logic [IDX_W-1:0] win_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else if (reg_we && reg_addr == '0) base_q <= reg_wdata;
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fld_q[s] <= 2'b00;
      else if (reg_we && reg_addr == ADDR_W'(s + 1)) fld_q[s] <= reg_wdata[1:0];
    end
    if (s < N_DBG) begin : g_dbg
      assign lvl_of[s] = fld_q[s];
    end else begin : g_per
      assign lvl_of[s] = fld_q[s] - 2'd1;
    end
    for (genvar l = 0; l < 4; l++) begin : g_lv
      assign hit[l][s] = irq_req[s] && (fld_q[s] != 2'b00) && (lvl_of[s] == 2'(l));
    end
  end

  always_comb begin
    reg_rdata = base_q;
    for (int s = 0; s < N_SRC; s++)
      if (reg_addr == ADDR_W'(s + 1)) reg_rdata = {{(VEC_W-2){1'b0}}, fld_q[s]};
  end

  for (genvar l = 0; l < 4; l++) begin : g_arb
    always_comb begin
      lvl_found[l] = 1'b0;
      lvl_idx[l]   = '0;
      for (int s = N_SRC - 1; s >= 0; s--)
        if (hit[l][s]) begin
          lvl_found[l] = 1'b1;
          lvl_idx[l]   = IDX_W'(s);
        end
    end
  end

  always_comb begin
    acc     = 1'b0;
    win_lvl = 2'd0;
    win_idx = '0;
    for (int l = 0; l < 4; l++)
      if (lvl_found[l] && 2'(l) >= core_mask) begin
        acc     = 1'b1;
        win_lvl = 2'(l);
        win_idx = lvl_idx[l];
      end
    if (!acc && swi_lp && core_mask == 2'd0) begin
      acc     = 1'b1;
      win_lvl = 2'd0;
      win_idx = IDX_W'(N_SRC);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_req <= 1'b0;
      int_vec <= '0;
      int_lvl <= 2'd0;
    end else if (int_req) begin
      if (int_ack) int_req <= 1'b0;
    end else if (acc) begin
      int_req <= 1'b1;
      int_vec <= base_q + (VEC_W'(win_idx) << 1);
      int_lvl <= win_lvl;
    end
  end

  assign wake = int_req | acc;
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int N_SRC = 8,
  parameter int VEC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] irq_req,
  input logic             swi_lp,
  input logic [1:0]       core_mask,
  input logic             int_ack,
  input logic             int_req,
  input logic [VEC_W-1:0] int_vec,
  input logic [1:0]       int_lvl,
  input logic             wake
);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_req && !int_ack |=> int_req && $stable(int_vec) && $stable(int_lvl));

  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_req && int_ack |=> !int_req);

  // R10
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> wake);

  // R5
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_req) |-> int_lvl >= $past(core_mask));

  // R2
  cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_req) |-> ($past(irq_req) != '0) || $past(swi_lp));
endmodule

bind prio_intc prio_intc_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .swi_lp(swi_lp),
  .core_mask(core_mask), .int_ack(int_ack), .int_req(int_req),
  .int_vec(int_vec), .int_lvl(int_lvl), .wake(wake)
);

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
  localparam int NS = 8;
  localparam int ND = 2;
  localparam int VW = 16;
  localparam int AW = 4;
  localparam logic [VW-1:0] BASE = 16'h0140;

  logic clk = 0, rst_n = 0, reg_we = 0, swi_lp = 0, int_ack = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [VW-1:0] reg_wdata = '0, reg_rdata, int_vec;
  logic [NS-1:0] irq_req = '0;
  logic [1:0] core_mask = '0, int_lvl;
  logic int_req, wake;

  int vectors = 0, fails = 0;
  int cfg [NS];
  logic e_acc; logic [VW-1:0] e_vec; logic [1:0] e_lvl;

  always #5 clk = ~clk;

  prio_intc #(.N_SRC(NS), .N_DBG(ND), .VEC_W(VW)) u_dut (.*);

  task automatic chk(input string r, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [VW-1:0] d);
    @(negedge clk); reg_we = 1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic model(input logic [NS-1:0] rq, input logic sw, input int m);
    e_acc = 0; e_vec = '0; e_lvl = 0;
    for (int l = 3; l >= 0 && !e_acc; l--) begin
      if (l < m) continue;
      for (int s = 0; s < NS && !e_acc; s++) begin
        int lv;
        if (cfg[s] == 0 || !rq[s]) continue;
        lv = (s < ND) ? cfg[s] : cfg[s] - 1;
        if (lv == l) begin e_acc = 1; e_vec = BASE + VW'(2 * s); e_lvl = 2'(l); end
      end
    end
    if (!e_acc && sw && m == 0) begin e_acc = 1; e_vec = BASE + VW'(2 * NS); e_lvl = 0; end
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 int_req", VW'(int_req), 0);
    chk("R1 wake", VW'(wake), 0);
    reg_addr = 0; #1 chk("R1 base", reg_rdata, 0);
    reg_addr = 3; #1 chk("R1 field", reg_rdata, 0);
    rst_n = 1;
    // R2 all disabled: requests ignored
    @(negedge clk); irq_req = '1;
    @(negedge clk); chk("R2 disabled", VW'(int_req), 0);
    irq_req = '0;
    // R11 register write/readback
    wr(0, BASE);
    reg_addr = 0; #1 chk("R11 base", reg_rdata, BASE);

    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < NS; s++) begin
        cfg[s] = (c == 0) ? 3 - (s % 4) : (s * c + c + s / 3) % 4;
        wr(s + 1, VW'(cfg[s]));
      end
      for (int s = 0; s < NS; s++) begin
        reg_addr = AW'(s + 1); #1 chk("R11 field", reg_rdata, VW'(cfg[s]));
      end
      for (int m = 0; m < 4; m++)
        for (int sw = 0; sw < 2; sw++)
          for (int p = 0; p < 256; p++) begin
            @(negedge clk);
            irq_req = NS'(p); swi_lp = sw[0]; core_mask = 2'(m);
            model(NS'(p), sw[0], m);
            @(negedge clk);
            // R3 R4 R5 R6 R7 R10
            chk("R4 int_req", VW'(int_req), VW'(e_acc));
            chk("R10 wake", VW'(wake), VW'(e_acc));
            if (e_acc) begin
              chk("R7 int_vec", int_vec, e_vec);
              chk("R3 int_lvl", VW'(int_lvl), VW'(e_lvl));
              int_ack = 1;
              @(negedge clk); int_ack = 0;
            end
            irq_req = '0; swi_lp = 0;
          end
    end

    // R8 R9 hold then re-arbitration
    for (int s = 0; s < NS; s++) begin cfg[s] = (s == 0) ? 3 : 1; wr(s + 1, VW'(cfg[s])); end
    @(negedge clk); core_mask = 0; irq_req = 8'h80;
    @(negedge clk); chk("R7 low src vec", int_vec, BASE + 16'd14);
    irq_req = 8'h81; core_mask = 3;
    repeat (3) @(negedge clk);
    chk("R8 held req", VW'(int_req), 1);
    chk("R8 held vec", int_vec, BASE + 16'd14);
    chk("R8 held lvl", VW'(int_lvl), 0);
    int_ack = 1;
    @(negedge clk); int_ack = 0;
    chk("R9 cleared", VW'(int_req), 0);
    @(negedge clk);
    chk("R9 rearm req", VW'(int_req), 1);
    chk("R9 rearm vec", int_vec, BASE);
    chk("R5 level3 under mask3", VW'(int_lvl), 3);
    int_ack = 1; irq_req = '0;
    @(negedge clk); int_ack = 0;
    @(negedge clk);
    chk("R9 idle", VW'(int_req), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule